// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic-logic stage of a small accumulator machine. Each clock it takes two data operands, an incoming carry, a four-bit operation code and a bit index. One clock later it presents a result, a condition-flag byte and a write-enable. The write-enable tells the surrounding datapath whether the result should replace the accumulator.

It supports nine operations:

- addition, with or without the incoming carry;
- subtraction, with or without the incoming carry as a borrow;
- compare, which subtracts but does not write;
- bitwise AND, OR and XOR;
- a single-bit test of the second operand.

The flag byte holds sign, zero, half-carry, a shared parity/overflow bit, a subtract marker and carry. Decimal adjust, shifts, rotates and the register file belong to other blocks.

Operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 bit test. Codes 9 to 15 are undefined.

Top module: `alu8_core`

## Requirements
- R1: After an add, subtract, AND, OR or XOR, flag bit 7 (sign) equals bit 7 of the result.
- R2: Flag bit 6 (zero) is 1 exactly when the 8-bit result of an add, subtract or logic operation is zero. After compare it is 1 exactly when both operands are equal.
- R3: Flag bit 4 (half-carry) has four cases:
  - after an add, it is the carry out of bit 3;
  - after a subtract or compare, it is the borrow into bit 4, with the incoming carry counted for subtract with borrow;
  - AND sets it to 1;
  - OR and XOR clear it.
- R4: After add, add with carry, subtract, subtract with borrow and compare, flag bit 2 is 1 when the signed two's-complement result (incoming carry included where used) lies outside -128..+127.
- R5: After AND, OR and XOR, flag bit 2 is 1 when the result has an even number of one bits.
- R6: Flag bit 1 is 1 after subtract, subtract with borrow and compare, and 0 after every other operation.
- R7: Flag bit 0 is the carry out of bit 7 after an add, the borrow out of bit 7 after a subtract or compare, and 0 after AND, OR and XOR.
- R8: Compare (code 4) drives write-enable 0 and returns the first operand unchanged as the result. Its flags are those of the subtraction of the second operand from the first.
- R9: Bit test (code 8) drives write-enable 0 and returns the first operand unchanged. Its flags are set as follows:
  - zero flag: the complement of the second operand's bit at the given index;
  - half-carry: 1;
  - flag bit 2: a copy of the zero flag;
  - sign and subtract marker: 0;
  - carry: the incoming carry.
- R10: Flag bits 5 and 3 are always 0.
- R11: An undefined code (9 to 15) yields result 0, flag byte 0 and write-enable 0.
- R12: Result, flags and write-enable appear one clock after the inputs are sampled, with write-enable 1 for codes 0-3 and 5-7. While reset is active all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry or borrow |
| bit_sel | input | 3 | Bit index for the bit test |
| result | output | 8 | Registered result |
| flags | output | 8 | Registered flag byte (S=7, Z=6, H=4, P/V=2, N=1, C=0) |
| wr_en | output | 1 | Registered accumulator write-enable |

## Verification
The only state is the output register, so a fault in the arithmetic or flag logic appears at the ports one clock after the offending inputs. The fault stays visible only for that single cycle before the next operation overwrites it. A wrong carry chain or borrow inversion shows in the carry, half-carry or overflow bit for particular operand pairs. For that reason add and subtract are swept over every operand pair, and the remaining operations are driven with random and corner operands. A wrong write-enable or pass-through on compare and bit test shows as an accumulator update that should not happen.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int FLAG_W = 8;
    localparam int FS  = 7;
    localparam int FZ  = 6;
    localparam int FH  = 4;
    localparam int FPV = 2;
    localparam int FN  = 1;
    localparam int FC  = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_BIT = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } alu_flags_t;

    function automatic logic [FLAG_W-1:0] pack_flags(alu_flags_t f);
        logic [FLAG_W-1:0] v;
        v      = '0;
        v[FS]  = f.s;
        v[FZ]  = f.z;
        v[FH]  = f.h;
        v[FPV] = f.pv;
        v[FN]  = f.n;
        v[FC]  = f.c;
        return v;
    endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         use_cin,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         carry_flag,
    output logic         half_flag,
    output logic         ovf
);
    localparam int HALF = W / 2;

    logic [W-1:0]  b_eff;
    logic          c0;
    logic [HALF:0] low_nib;
    logic [W-1:0]  low_body;
    logic [W:0]    full;

    always_comb begin
        b_eff    = subtract ? ~b : b;
        c0       = subtract ? ~(use_cin & cin) : (use_cin & cin);
        low_nib  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c0};
        low_body = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, c0};
        full     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum        = full[W-1:0];
        carry_flag = subtract ? ~full[W] : full[W];
        half_flag  = subtract ? ~low_nib[HALF] : low_nib[HALF];
        ovf        = full[W] ^ low_body[W-1];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res,
    output logic         even
);
    always_comb begin
        case (sel)
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
        even = ~(^res);
    end
endmodule

// File: rtl/alu8_bittest.sv
module alu8_bittest #(
    parameter int W    = 8,
    parameter int SELW = $clog2(W)
) (
    input  logic [W-1:0]    value,
    input  logic [SELW-1:0] idx,
    output logic            bit_clear
);
    always_comb bit_clear = ~value[idx];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W    = 8,
    parameter int SELW = $clog2(W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op,
    input  logic [W-1:0]        opa,
    input  logic [W-1:0]        opb,
    input  logic                carry_in,
    input  logic [SELW-1:0]     bit_sel,
    output logic [W-1:0]        result,
    output logic [FLAG_W-1:0]   flags,
    output logic                wr_en
);
    typedef struct packed {
        logic [W-1:0]      res;
        logic [FLAG_W-1:0] flg;
        logic              wr;
    } stage_t;

    stage_t     stage_d, stage_q;
    alu_op_e    op_sel;
    logic       is_sub, is_cin;
    logic_sel_e lg_sel;

    logic [W-1:0] ar_sum, lg_res;
    logic         ar_c, ar_h, ar_v, lg_even, bt_zero;

    always_comb begin
        op_sel = alu_op_e'(op);
        is_sub = (op_sel == OP_SUB) || (op_sel == OP_SBC) || (op_sel == OP_CMP);
        is_cin = (op_sel == OP_ADC) || (op_sel == OP_SBC);
        case (op_sel)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .a(opa), .b(opb), .cin(carry_in), .use_cin(is_cin), .subtract(is_sub),
        .sum(ar_sum), .carry_flag(ar_c), .half_flag(ar_h), .ovf(ar_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .a(opa), .b(opb), .sel(lg_sel), .res(lg_res), .even(lg_even)
    );

    alu8_bittest #(.W(W), .SELW(SELW)) u_bit (
        .value(opb), .idx(bit_sel), .bit_clear(bt_zero)
    );

    always_comb begin
        alu_flags_t f;
        f       = '0;
        stage_d = '0;
        case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                f.s  = ar_sum[W-1];
                f.z  = (ar_sum == '0);
                f.h  = ar_h;
                f.pv = ar_v;
                f.n  = is_sub;
                f.c  = ar_c;
                stage_d.res = (op_sel == OP_CMP) ? opa : ar_sum;
                stage_d.wr  = (op_sel != OP_CMP);
                stage_d.flg = pack_flags(f);
            end
            OP_AND, OP_OR, OP_XOR: begin
                f.s  = lg_res[W-1];
                f.z  = (lg_res == '0);
                f.h  = (op_sel == OP_AND);
                f.pv = lg_even;
                stage_d.res = lg_res;
                stage_d.wr  = 1'b1;
                stage_d.flg = pack_flags(f);
            end
            OP_BIT: begin
                f.z  = bt_zero;
                f.h  = 1'b1;
                f.pv = bt_zero;
                f.c  = carry_in;
                stage_d.res = opa;
                stage_d.wr  = 1'b0;
                stage_d.flg = pack_flags(f);
            end
            default: stage_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign result = stage_q.res;
    assign flags  = stage_q.flg;
    assign wr_en  = stage_q.wr;

    a_r1_sign_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> flags[FS] == result[W-1]);

    a_r2_zero_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> flags[FZ] == (result == '0));

    a_r6_sub_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd2 || op == 4'd3 || op == 4'd4) |=> flags[FN]);

    a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd4) |=> (!wr_en && result == $past(opa)));

    a_r9_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd8) |=> (flags[FZ] == !$past(opb[bit_sel]) && !wr_en));

    a_r11_undefined_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd8) |=> (flags == '0 && result == '0 && !wr_en));

    a_r10_spare_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flags[5] == 1'b0 && flags[3] == 1'b0));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] opa = '0, opb = '0;
    logic       carry_in = 1'b0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result, flags;
    logic       wr_en;

    int checks = 0;
    int errors = 0;
    bit pend = 0;
    int e_res, e_flg, e_wr, e_op, e_a, e_b;

    always #(PERIOD/2) clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
        .carry_in(carry_in), .bit_sel(bit_sel),
        .result(result), .flags(flags), .wr_en(wr_en)
    );

    function automatic void model(input int o, input int a, input int b, input int ci,
                                  input int sel, output int r, output int f, output int w);
        int s = 0, z = 0, h = 0, pv = 0, n = 0, c = 0;
        int res, full, lo, sa, sb, sr, k, ones;
        r = 0; w = 0;
        if (o <= 4) begin
            k  = (o == 1 || o == 3) ? ci : 0;
            sa = (a > 127) ? a - 256 : a;
            sb = (b > 127) ? b - 256 : b;
            if (o <= 1) begin
                full = a + b + k; lo = (a % 16) + (b % 16) + k;
                h = (lo > 15); c = (full > 255); sr = sa + sb + k;
            end else begin
                full = a - b - k; lo = (a % 16) - (b % 16) - k;
                h = (lo < 0); c = (full < 0); sr = sa - sb - k; n = 1;
            end
            res = full & 255;
            pv = (sr > 127 || sr < -128);
            s = (res > 127); z = (res == 0);
            if (o == 4) begin r = a; w = 0; end
            else begin r = res; w = 1; end
        end else if (o <= 7) begin
            res = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
            pv = (ones % 2 == 0); h = (o == 5);
            s = (res > 127); z = (res == 0);
            r = res; w = 1;
        end else if (o == 8) begin
            z = (((b >> sel) & 1) == 0); h = 1; pv = z; c = ci;
            r = a; w = 0;
        end
        f = (s << 7) | (z << 6) | (h << 4) | (pv << 2) | (n << 1) | c;
    endfunction

    function automatic string res_tag(int o);
        if (o == 4) return "R8";
        if (o == 8) return "R9";
        if (o > 8)  return "R11";
        return "R12";
    endfunction

    function automatic string flag_tag(int o, int b);
        if (o == 4 && b == 6) return "R8";
        if (o == 8) return "R9";
        if (o > 8)  return "R11";
        case (b)
            7: return "R1";
            6: return "R2";
            4: return "R3";
            2: return (o >= 5) ? "R5" : "R4";
            1: return "R6";
            0: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check_out();
        checks++;
        if (result !== 8'(e_res)) begin
            errors++;
            $display("FAIL %s result op=%0d a=%02h b=%02h: got %02h expected %02h",
                     res_tag(e_op), e_op, e_a, e_b, result, e_res);
        end
        checks++;
        if (wr_en !== 1'(e_wr)) begin
            errors++;
            $display("FAIL %s wr_en op=%0d a=%02h b=%02h: got %0d expected %0d",
                     res_tag(e_op), e_op, e_a, e_b, wr_en, e_wr);
        end
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (flags[i] !== 1'((e_flg >> i) & 1)) begin
                errors++;
                $display("FAIL %s flag bit %0d op=%0d a=%02h b=%02h: got %0d expected %0d",
                         flag_tag(e_op, i), i, e_op, e_a, e_b, flags[i], (e_flg >> i) & 1);
            end
        end
    endtask

    task automatic step(int o, int a, int b, int ci, int sel);
        @(negedge clk);
        if (pend) check_out();
        op = 4'(o); opa = 8'(a); opb = 8'(b); carry_in = 1'(ci); bit_sel = 3'(sel);
        model(o, a, b, ci, sel, e_res, e_flg, e_wr);
        e_op = o; e_a = a; e_b = b;
        pend = 1;
    endtask

    initial begin
        #(PERIOD * 190000);
        errors++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        op = 4'd1; opa = 8'hFF; opb = 8'hFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        // R12: outputs held at zero while reset is active
        checks++;
        if (result !== 8'h00 || flags !== 8'h00 || wr_en !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got %02h/%02h/%0d expected 00/00/0", result, flags, wr_en);
        end
        rst_n = 1'b1;

        // corner vectors: R4 overflow, R3 half-carry, R7 carry/borrow, R2 zero
        step(0, 8'h78, 8'h69, 0, 0);
        step(0, 8'h80, 8'h80, 0, 0);
        step(1, 8'h0F, 8'h00, 1, 0);
        step(1, 8'hFF, 8'h00, 1, 0);
        step(2, 8'h7F, 8'hC0, 0, 0);
        step(2, 8'h00, 8'h01, 0, 0);
        step(3, 8'h10, 8'h00, 1, 0);
        step(3, 8'h80, 8'h00, 1, 0);
        step(4, 8'h5A, 8'h5A, 1, 0);   // R8 equal operands
        step(4, 8'h01, 8'h02, 0, 0);
        step(5, 8'hF0, 8'h0F, 0, 0);   // R5 zero result, even parity
        step(6, 8'h01, 8'h02, 0, 0);
        step(7, 8'hFF, 8'h01, 0, 0);
        step(8, 8'h11, 8'h80, 1, 7);   // R9 bit set
        step(8, 8'h22, 8'h7F, 0, 7);   // R9 bit clear
        step(9, 8'hFF, 8'hFF, 1, 3);   // R11
        step(15, 8'h12, 8'h34, 0, 1);

        // exhaustive add and subtract
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(0, a, b, 0, 0);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(2, a, b, 0, 0);

        // random over every code, including undefined ones
        for (int i = 0; i < 6000; i++)
            step(int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
                 int'($urandom_range(255, 0)), int'($urandom_range(1, 0)),
                 int'($urandom_range(7, 0)));

        @(negedge clk);
        check_out();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule